// File: doc/BRIEF.md
# Parallel Read Master with Wait-State Extension

This block drives the requesting side of a simple parallel read bus. On a start pulse from internal logic it raises a request line toward a slave. It counts a fixed access window in clock cycles, then decides from the slave's wait line whether the data word on the bus can be taken at once. A slave that needs more time keeps wait high, and the master holds its request until wait drops. The master then captures the data, removes the request and reports completion with a one-cycle pulse.

If wait stays high past a programmable number of extra cycles, the master gives up. It drops the request, pulses an error flag and keeps the last good data word. After every transfer the request goes through a release cycle and an idle cycle before another read can start. This lets the slave see the request removed before the next one arrives.

Top module: `par_read_master`

## Requirements
- R1: After reset the request, done and error outputs are low and the data output is all zeros.
- R2: A start pulse seen in the idle state raises the request on the next cycle. A start seen while the request is high, or during the release cycle, starts no transfer.
- R3: The wait line is sampled on the clock edge that ends the ACC_CYC-th cycle of request high. If it is low there, the bus data is captured on that edge. Done is high for exactly that one following cycle, and the request goes low in that same cycle.
- R4: If wait is high at the sampling edge, the request stays high for as long as wait is sampled high, up to the limit. The data is captured on the first edge at which wait is sampled low, with the request falling and done pulsing as in R3. The request is therefore high for ACC_CYC plus the number of wait-high samples.
- R5: If wait is sampled high on WAIT_LIMIT consecutive edges after the access window, the request falls after ACC_CYC+WAIT_LIMIT cycles high. The error output pulses for one cycle, done stays low, and the data output keeps its prior value. Exactly WAIT_LIMIT wait-high samples followed by a low sample still completes normally.
- R6: Once the request falls, it stays low through a release cycle and an idle cycle. With start held high continuously, consecutive requests are separated by exactly two low cycles.
- R7: The data output changes only on a successful capture and otherwise holds its value.
- R8: Done and error are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_start_i | input | 1 | Start a read (taken only when idle) |
| rd_data_o | output | DATA_W | Last successfully captured word |
| rd_done_o | output | 1 | One-cycle pulse: read completed |
| rd_err_o | output | 1 | One-cycle pulse: wait timeout |
| bus_req_o | output | 1 | Request to the slave |
| bus_wait_i | input | 1 | Slave stretches the cycle while high |
| bus_data_i | input | DATA_W | Data word from the slave |

## Verification
Reads are issued against a fast slave and against slow slaves that hold wait for one, several, exactly WAIT_LIMIT and WAIT_LIMIT+1 samples. Together these separate the fast path, the extended path, the boundary at the timeout and the timeout itself. The slave drives the inverse of the correct word until its data is due, so a capture made one edge early or late shows up as a wrong word. A start pulse given in the middle of a stretched read tells an ignored start apart from a queued one. A start held high across back-to-back reads measures the exact release gap.

// File: rtl/prm_pkg.sv
package prm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_WAIT    = 2'd2,
    ST_RELEASE = 2'd3
  } prm_state_e;
endpackage

// File: rtl/prm_counter.sv
module prm_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/prm_capture.sv
module prm_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  p_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/prm_fsm.sv
module prm_fsm
  import prm_pkg::*;
#(
  parameter int ACC_CYC    = 4,
  parameter int WAIT_LIMIT = 32,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wait_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             load_o,
  output logic             req_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] AccLast  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WaitLast = CNT_W'(WAIT_LIMIT - 1);

  prm_state_e state_q, state_d;
  logic done_d, err_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_en_o  = 1'b0;
    load_o    = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_ACCESS;
        cnt_clr_o = 1'b1;
      end
      ST_ACCESS: begin
        if (cnt_i == AccLast) begin
          cnt_clr_o = 1'b1;
          if (wait_i) state_d = ST_WAIT;
          else begin
            load_o  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_RELEASE;
          end
        end else cnt_en_o = 1'b1;
      end
      ST_WAIT: begin
        if (!wait_i) begin
          load_o  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_RELEASE;
        end else if (cnt_i == WaitLast) begin
          err_d   = 1'b1;
          state_d = ST_RELEASE;
        end else cnt_en_o = 1'b1;
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      err_o   <= err_d;
    end
  end

  assign req_o = (state_q == ST_ACCESS) || (state_q == ST_WAIT);

  p_done_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  p_release_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |=> !req_o);
  p_err_drops_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_o);
  p_wait_holds_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && wait_i && cnt_i != WaitLast) |=> req_o);
endmodule

// File: rtl/par_read_master.sv
module par_read_master #(
  parameter int DATA_W     = 16,
  parameter int ACC_CYC    = 4,
  parameter int WAIT_LIMIT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_start_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_done_o,
  output logic              rd_err_o,
  output logic              bus_req_o,
  input  logic              bus_wait_i,
  input  logic [DATA_W-1:0] bus_data_i
);
  localparam int MaxCnt = (ACC_CYC > WAIT_LIMIT) ? ACC_CYC : WAIT_LIMIT;
  localparam int CntW   = $clog2(MaxCnt + 1);

  logic [CntW-1:0] cnt;
  logic cnt_clr, cnt_en, load;

  prm_counter #(.CNT_W(CntW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  prm_fsm #(
    .ACC_CYC   (ACC_CYC),
    .WAIT_LIMIT(WAIT_LIMIT),
    .CNT_W     (CntW)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rd_start_i),
    .wait_i   (bus_wait_i),
    .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr),
    .cnt_en_o (cnt_en),
    .load_o   (load),
    .req_o    (bus_req_o),
    .done_o   (rd_done_o),
    .err_o    (rd_err_o)
  );

  prm_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .d_i   (bus_data_i),
    .q_o   (rd_data_o)
  );

  p_req_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(rd_start_i));
endmodule

// File: tb/tb_par_read_master.sv
module tb_par_read_master;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int ACC = 4;
  localparam int LIM = 8;

  logic clk = 0, rst_n = 0, start = 0, bwait = 0;
  logic [DW-1:0] bdata = '0, rdata;
  logic done, err, req;

  par_read_master #(.DATA_W(DW), .ACC_CYC(ACC), .WAIT_LIMIT(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_start_i(start), .rd_data_o(rdata),
    .rd_done_o(done), .rd_err_o(err), .bus_req_o(req),
    .bus_wait_i(bwait), .bus_data_i(bdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [DW-1:0] q_data[$];
  bit            q_err[$];
  int            q_len[$];
  logic [DW-1:0] cur_data = '0, last_good = '0;
  int cur_hold = 0, reqcnt = 0, last_len = 0, lowcnt = 0, rises = 0;
  bit gap_chk = 0, prev_done = 0, prev_err = 0;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // slave model and monitor, both on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (req) begin
        if (reqcnt == 0) begin
          rises++;
          if (gap_chk) check(lowcnt == 2, "R6", "low gap", lowcnt, 2);
        end
        reqcnt++;
        lowcnt = 0;
      end else begin
        if (reqcnt > 0) last_len = reqcnt;
        reqcnt = 0;
        lowcnt++;
      end
      bwait = req && (cur_hold > 0) && (reqcnt < ACC + cur_hold);
      bdata = (req && !bwait && reqcnt >= ACC) ? cur_data : ~cur_data;
      if (prev_done) check(!done, "R8", "done width", done, 0);
      if (prev_err)  check(!err, "R8", "err width", err, 0);
      if (done || err) begin
        check(!(done && err), "R8", "done with err", done && err, 0);
        if (q_data.size() == 0) check(0, "R2", "unexpected completion", 1, 0);
        else begin
          automatic logic [DW-1:0] ed = q_data.pop_front();
          automatic bit ee = q_err.pop_front();
          automatic int el = q_len.pop_front();
          check(err == ee, ee ? "R5" : "R3", "err flag", err, ee);
          check(done == !ee, ee ? "R5" : "R4", "done flag", done, !ee);
          check(rdata == ed, ee ? "R7" : "R3", "data", rdata, ed);
          check(!req, "R3", "req after end", req, 0);
          check(last_len == el, ee ? "R5" : "R4", "req length", last_len, el);
        end
      end
      prev_done = done;
      prev_err  = err;
    end
  end

  task automatic issue(input logic [DW-1:0] d, input int hold);
    bit e;
    e = hold > LIM;
    cur_data = d;
    cur_hold = hold;
    q_data.push_back(e ? last_good : d);
    q_err.push_back(e);
    q_len.push_back(e ? ACC + LIM : ACC + hold);
    if (!e) last_good = d;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic finish_wait();
    while (!(done || err)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!req, "R1", "req", req, 0);
    check(!done && !err, "R1", "done/err", done | err, 0);
    check(rdata == '0, "R1", "data", rdata, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    issue(16'h1234, 0); finish_wait();       // R3 fast
    issue(16'hA5A5, 1); finish_wait();       // R4 one wait sample
    issue(16'h0F0F, 5); finish_wait();       // R4 several
    issue(16'h7E81, LIM); finish_wait();     // R5 boundary, success
    issue(16'hBEEF, LIM + 1); finish_wait(); // R5 timeout, data kept
    check(rdata == 16'h7E81, "R7", "data after timeout", rdata, 16'h7E81);

    // R2: start pulse mid-transfer must be ignored
    begin
      automatic int r0 = rises;
      issue(16'hC3C3, 3);
      repeat (2) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
      finish_wait();
      repeat (6) @(negedge clk);
      check(rises == r0 + 1, "R2", "requests issued", rises - r0, 1);
      check(!req, "R2", "req idle", req, 0);
    end

    // R6: start held high, back-to-back reads
    cur_data = 16'h5A5A; cur_hold = 0;
    for (int i = 0; i < 3; i++) begin
      q_data.push_back(16'h5A5A); q_err.push_back(0); q_len.push_back(ACC);
    end
    last_good = 16'h5A5A;
    @(negedge clk) start = 1;
    while (rises == 0 || !done) @(negedge clk);
    gap_chk = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      while (!done) @(negedge clk);
    end
    start = 0;
    gap_chk = 0;
    repeat (8) @(negedge clk);
    check(q_data.size() == 0, "R6", "pending items", q_data.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule